// File: doc/BRIEF.md
# Delimited Status Packet Framer

The framer turns a status report request into a delimited packet on a 16-bit word stream with valid/ready flow control. A request carries a packet type and a payload length. Once accepted, the block emits a start marker and a fixed header that describes the packet and the unit's condition. It then forwards exactly the announced number of payload words from a separate payload port and closes the packet with an end marker.

The header holds the packet type, a size field, a state word, a 64-bit chip identifier, a firmware version, a 32-bit trigger count and a 64-bit microsecond timestamp. The size field counts the words after the header, including the end marker. The block keeps the timestamp itself. A programmable prescaler divides the system clock into microsecond ticks, and a run-boundary pulse clears the timestamp. All header fields are captured in the cycle the start marker is loaded, so a packet always describes a single instant.

Top module: `status_framer`

## Requirements
- R1: Every packet begins with the word 0xFB01 and ends with the word 0x04FE.
- R2: Header order is: start marker, type, size, state, chip identifier (4 words), firmware version, trigger count (2 words), timestamp (4 words). These 15 words are followed by the payload and then the end marker. Multi-word fields go most significant word first.
- R3: The type word is `reqType` zero-extended to 16 bits (1 static configuration, 2 dynamic rates, 3 board list, 4 error list, 5 register value). The size word equals `reqLen` + 1.
- R4: The state word carries `stateCode` in bits 7:0, the clock-lock flag in bit 8 (0x100), and zeros in bits 15:9. Example codes: 1 idle, 2 configuring, 3 running, 4 calibrating.
- R5: The header field inputs are sampled on the clock edge that accepts the request. Changes to them after that edge do not affect the packet being sent.
- R6: The timestamp advances by one every `usPrescale`+1 clock cycles. It returns to 0 on any edge where `runRestart` is high, and on reset. The header reports the value present at the accept edge.
- R7: Exactly `reqLen` payload words are forwarded in arrival order. With `reqLen` = 0, the end marker follows the last header word directly.
- R8: While `outValid` is high and `outReady` is low, `outData` and `outValid` hold. No word is dropped or repeated.
- R9: After reset `outValid` is 0 and `reqReady` is 1. `reqReady` is high only while no packet is in progress and the output stage can take a word.
- R10: `plReady` is low outside the payload phase of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| usPrescale | input | 8 | Clock cycles per microsecond minus one |
| runRestart | input | 1 | Clears the microsecond timestamp |
| reqValid | input | 1 | Report request present |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqType | input | 3 | Packet type code |
| reqLen | input | 16 | Payload word count (end marker excluded) |
| stateCode | input | 8 | Central state code |
| clkLocked | input | 1 | Clock lock flag |
| boardId | input | 64 | Chip identifier |
| fwVersion | input | 16 | Firmware version |
| trigCount | input | 32 | Trigger counter value |
| plData | input | 16 | Payload word |
| plValid | input | 1 | Payload word present |
| plReady | output | 1 | Payload word taken when high with plValid |
| outData | output | 16 | Output stream word |
| outValid | output | 1 | Output word present |
| outReady | input | 1 | Downstream accepts the word |

## Verification
The bench first sends packets with no payload. A framer that treated the size field as the payload count, or that expected at least one payload word, would hang waiting for data or emit a stray word before the end marker. It then throttles `outReady` and `plValid` heavily and independently. This exposes a stage that overwrites a stalled word, or one that pulls a payload word while the output is full: the packet comes out with a lost or duplicated word, and its length is wrong. The bench also changes every header input just after acceptance and pulses the run restart with different prescaler settings. A design that read live inputs mid-packet, or miscounted the tick period, would report a torn header or a shifted timestamp.

// File: rtl/statfrm_pkg.sv
package statfrm_pkg;
  localparam int WORD_W   = 16;
  localparam int LEN_W    = 16;
  localparam int TYPE_W   = 3;
  localparam int STATE_W  = 8;
  localparam int BOARD_W  = 64;
  localparam int FW_W     = 16;
  localparam int TRIG_W   = 32;
  localparam int TS_W     = 64;
  localparam int PRESC_W  = 8;

  localparam int BOARD_WORDS = BOARD_W / WORD_W;
  localparam int TRIG_WORDS  = TRIG_W / WORD_W;
  localparam int TS_WORDS    = TS_W / WORD_W;
  // start, type, size, state, board, firmware, trigger, timestamp
  localparam int HDR_WORDS   = 4 + BOARD_WORDS + 1 + TRIG_WORDS + TS_WORDS;
  localparam int IDX_W       = $clog2(HDR_WORDS);

  localparam int BOARD_BASE  = 4;
  localparam int FW_POS      = BOARD_BASE + BOARD_WORDS;
  localparam int TRIG_BASE   = FW_POS + 1;
  localparam int TS_BASE     = TRIG_BASE + TRIG_WORDS;

  localparam logic [WORD_W-1:0] START_MARK = 16'hFB01;
  localparam logic [WORD_W-1:0] END_MARK   = 16'h04FE;

  typedef enum logic [1:0] {SEL_START, SEL_HDR, SEL_PAY, SEL_END} wordSel_e;

  typedef struct packed {
    logic             latchHdr;
    logic             loadWord;
    wordSel_e         sel;
    logic [IDX_W-1:0] hdrIdx;
  } strobe_t;
endpackage

// File: rtl/statfrm_ustimer.sv
module statfrm_ustimer
  import statfrm_pkg::*;
#(
  parameter int PW = PRESC_W,
  parameter int TW = TS_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [PW-1:0] usPrescale,
  input  logic          runRestart,
  output logic [TW-1:0] tsValue
);
  logic [PW-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (!rstN || runRestart) begin
      divCnt  <= '0;
      tsValue <= '0;
    end else if (divCnt == usPrescale) begin
      divCnt  <= '0;
      tsValue <= tsValue + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // R6
  ts_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    runRestart |=> tsValue == '0);

  // R6
  ts_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runRestart |=> (tsValue == $past(tsValue) || tsValue == $past(tsValue) + 1'b1));
endmodule

// File: rtl/statfrm_ctrl.sv
module statfrm_ctrl
  import statfrm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             plValid,
  input  logic             outValid,
  input  logic             outReady,
  output logic             reqReady,
  output logic             plReady,
  output strobe_t          strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY, ST_TAIL} phase_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_WORDS - 1);

  phase_e           phase;
  logic [IDX_W-1:0] hdrIdx;
  logic [LEN_W-1:0] remain;
  logic             canLoad;

  assign canLoad  = !outValid || outReady;
  assign reqReady = (phase == ST_IDLE) && canLoad;
  assign plReady  = (phase == ST_PAY) && canLoad;

  always_comb begin
    strb          = '0;
    strb.sel      = SEL_START;
    strb.hdrIdx   = hdrIdx;
    unique case (phase)
      ST_IDLE: begin
        strb.latchHdr = reqValid && canLoad;
        strb.loadWord = reqValid && canLoad;
        strb.sel      = SEL_START;
      end
      ST_HDR: begin
        strb.loadWord = canLoad;
        strb.sel      = SEL_HDR;
      end
      ST_PAY: begin
        strb.loadWord = canLoad && plValid;
        strb.sel      = SEL_PAY;
      end
      ST_TAIL: begin
        strb.loadWord = canLoad;
        strb.sel      = SEL_END;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= ST_IDLE;
      hdrIdx <= '0;
      remain <= '0;
    end else begin
      unique case (phase)
        ST_IDLE: if (reqValid && canLoad) begin
          phase  <= ST_HDR;
          hdrIdx <= IDX_W'(1);
          remain <= reqLen;
        end
        ST_HDR: if (canLoad) begin
          if (hdrIdx == LAST_IDX)
            phase <= (remain == '0) ? ST_TAIL : ST_PAY;
          else
            hdrIdx <= hdrIdx + 1'b1;
        end
        ST_PAY: if (canLoad && plValid) begin
          remain <= remain - 1'b1;
          if (remain == LEN_W'(1)) phase <= ST_TAIL;
        end
        ST_TAIL: if (canLoad) phase <= ST_IDLE;
        default: phase <= ST_IDLE;
      endcase
    end
  end

  // R7
  pay_forward_chk: assert property (@(posedge clk) disable iff (!rstN)
    plValid && plReady |=> outValid);

  // R10
  pay_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !plReady);
endmodule

// File: rtl/statfrm_datapath.sv
module statfrm_datapath
  import statfrm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [TYPE_W-1:0]  reqType,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [STATE_W-1:0] stateCode,
  input  logic               clkLocked,
  input  logic [BOARD_W-1:0] boardId,
  input  logic [FW_W-1:0]    fwVersion,
  input  logic [TRIG_W-1:0]  trigCount,
  input  logic [TS_W-1:0]    tsValue,
  input  logic [WORD_W-1:0]  plData,
  input  logic               outReady,
  output logic [WORD_W-1:0]  outData,
  output logic               outValid
);
  logic [WORD_W-1:0]  typeWord, sizeWord, stateWord;
  logic [BOARD_W-1:0] boardReg;
  logic [FW_W-1:0]    fwReg;
  logic [TRIG_W-1:0]  trigReg;
  logic [TS_W-1:0]    tsReg;
  logic [WORD_W-1:0]  hdrWord, nextWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      typeWord  <= '0;
      sizeWord  <= '0;
      stateWord <= '0;
      boardReg  <= '0;
      fwReg     <= '0;
      trigReg   <= '0;
      tsReg     <= '0;
    end else if (strb.latchHdr) begin
      typeWord  <= WORD_W'(reqType);
      sizeWord  <= WORD_W'(reqLen) + 1'b1;
      stateWord <= {{(WORD_W-STATE_W-1){1'b0}}, clkLocked, stateCode};
      boardReg  <= boardId;
      fwReg     <= fwVersion;
      trigReg   <= trigCount;
      tsReg     <= tsValue;
    end
  end

  // Split wide fields into word slots, most significant word first.
  logic [WORD_W-1:0] boardSlot [BOARD_WORDS];
  logic [WORD_W-1:0] trigSlot  [TRIG_WORDS];
  logic [WORD_W-1:0] tsSlot    [TS_WORDS];

  for (genvar g = 0; g < BOARD_WORDS; g++) begin : g_board
    assign boardSlot[g] = boardReg[WORD_W*(BOARD_WORDS-1-g) +: WORD_W];
  end
  for (genvar g = 0; g < TRIG_WORDS; g++) begin : g_trig
    assign trigSlot[g] = trigReg[WORD_W*(TRIG_WORDS-1-g) +: WORD_W];
  end
  for (genvar g = 0; g < TS_WORDS; g++) begin : g_ts
    assign tsSlot[g] = tsReg[WORD_W*(TS_WORDS-1-g) +: WORD_W];
  end

  always_comb begin
    hdrWord = '0;
    for (int k = 0; k < HDR_WORDS; k++) begin
      if (strb.hdrIdx == IDX_W'(k)) begin
        if (k == 1)                                      hdrWord = typeWord;
        else if (k == 2)                                 hdrWord = sizeWord;
        else if (k == 3)                                 hdrWord = stateWord;
        else if (k >= BOARD_BASE && k < FW_POS)          hdrWord = boardSlot[k-BOARD_BASE];
        else if (k == FW_POS)                            hdrWord = fwReg;
        else if (k >= TRIG_BASE && k < TS_BASE)          hdrWord = trigSlot[k-TRIG_BASE];
        else if (k >= TS_BASE)                           hdrWord = tsSlot[k-TS_BASE];
      end
    end
  end

  always_comb begin
    unique case (strb.sel)
      SEL_START: nextWord = START_MARK;
      SEL_HDR:   nextWord = hdrWord;
      SEL_PAY:   nextWord = plData;
      SEL_END:   nextWord = END_MARK;
      default:   nextWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (strb.loadWord) begin
      outValid <= 1'b1;
      outData  <= nextWord;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));
endmodule

// File: rtl/status_framer.sv
module status_framer
  import statfrm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PRESC_W-1:0] usPrescale,
  input  logic               runRestart,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [TYPE_W-1:0]  reqType,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [STATE_W-1:0] stateCode,
  input  logic               clkLocked,
  input  logic [BOARD_W-1:0] boardId,
  input  logic [FW_W-1:0]    fwVersion,
  input  logic [TRIG_W-1:0]  trigCount,
  input  logic [WORD_W-1:0]  plData,
  input  logic               plValid,
  output logic               plReady,
  output logic [WORD_W-1:0]  outData,
  output logic               outValid,
  input  logic               outReady
);
  strobe_t          strb;
  logic [TS_W-1:0]  tsValue;

  statfrm_ustimer #(.PW(PRESC_W), .TW(TS_W)) u_timer (
    .clk(clk), .rstN(rstN), .usPrescale(usPrescale),
    .runRestart(runRestart), .tsValue(tsValue)
  );

  statfrm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .plValid(plValid), .outValid(outValid), .outReady(outReady),
    .reqReady(reqReady), .plReady(plReady), .strb(strb)
  );

  statfrm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqType(reqType), .reqLen(reqLen),
    .stateCode(stateCode), .clkLocked(clkLocked), .boardId(boardId),
    .fwVersion(fwVersion), .trigCount(trigCount), .tsValue(tsValue),
    .plData(plData), .outReady(outReady), .outData(outData), .outValid(outValid)
  );

  // R1
  start_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> outValid && outData == START_MARK);
endmodule

// File: tb/status_framer_bench.sv
module status_framer_bench;
  import statfrm_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  usPrescale = 8'd0;
  logic        runRestart = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqType = 3'd1;
  logic [15:0] reqLen = 16'd0;
  logic [7:0]  stateCode = 8'd1;
  logic        clkLocked = 1'b0;
  logic [63:0] boardId = 64'h0;
  logic [15:0] fwVersion = 16'h0;
  logic [31:0] trigCount = 32'h0;
  logic [15:0] plData = 16'h0;
  logic        plValid = 1'b0;
  logic        plReady;
  logic [15:0] outData;
  logic        outValid;
  logic        outReady = 1'b0;

  status_framer u_status_framer (
    .clk(clk), .rstN(rstN), .usPrescale(usPrescale), .runRestart(runRestart),
    .reqValid(reqValid), .reqReady(reqReady), .reqType(reqType), .reqLen(reqLen),
    .stateCode(stateCode), .clkLocked(clkLocked), .boardId(boardId),
    .fwVersion(fwVersion), .trigCount(trigCount), .plData(plData),
    .plValid(plValid), .plReady(plReady), .outData(outData),
    .outValid(outValid), .outReady(outReady)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Timestamp model from R6
  logic [7:0]  mCnt;
  logic [63:0] mTs;
  always @(posedge clk) begin
    if (!rstN || runRestart) begin
      mCnt <= 8'd0;
      mTs  <= 64'd0;
    end else if (mCnt == usPrescale) begin
      mCnt <= 8'd0;
      mTs  <= mTs + 64'd1;
    end else begin
      mCnt <= mCnt + 8'd1;
    end
  end

  logic [15:0] cap [0:255];
  logic [15:0] pay [0:63];
  int capCnt = 0;
  int plIdx = 0;
  int plLen = 0;
  int readyMode = 1;
  logic prevStall = 1'b0;
  logic [15:0] prevData = 16'h0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) check("R8", "stalled word held", {47'd0, outValid, outData}, {47'd0, 1'b1, prevData});
      case (readyMode)
        0: outReady = ($urandom % 2) == 0;
        1: outReady = 1'b1;
        default: outReady = ($urandom % 5) == 0;
      endcase
      plValid = (plIdx < plLen) && (($urandom % 4) != 0);
      plData  = pay[plIdx[5:0]];
      #1;
      if (outValid && outReady) begin
        cap[capCnt[7:0]] = outData;
        capCnt++;
      end
      if (plValid && plReady) plIdx++;
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
  end

  logic [15:0] exHdr [0:14];

  function automatic logic [15:0] stateWordOf(input logic [7:0] s, input logic l);
    return {7'd0, l, s};
  endfunction

  task automatic sendPkt(input logic [2:0] t, input int len, input bit scramble);
    logic [63:0] snapTs;
    plLen = 0;
    plIdx = 0;
    for (int i = 0; i < len; i++) pay[i] = 16'($urandom);
    @(negedge clk);
    capCnt = 0;
    plLen = len;
    reqType = t;
    reqLen = 16'(len);
    reqValid = 1'b1;
    forever begin
      #2;
      if (reqReady) break;
      @(negedge clk);
    end
    snapTs = mTs;
    exHdr[0] = START_MARK;
    exHdr[1] = {13'd0, t};
    exHdr[2] = 16'(len + 1);
    exHdr[3] = stateWordOf(stateCode, clkLocked);
    for (int i = 0; i < 4; i++) exHdr[4+i] = boardId[16*(3-i) +: 16];
    exHdr[8] = fwVersion;
    exHdr[9] = trigCount[31:16];
    exHdr[10] = trigCount[15:0];
    for (int i = 0; i < 4; i++) exHdr[11+i] = snapTs[16*(3-i) +: 16];
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    if (scramble) begin
      stateCode = ~stateCode;
      clkLocked = ~clkLocked;
      boardId = ~boardId;
      fwVersion = ~fwVersion;
      trigCount = ~trigCount;
      reqType = ~reqType;
      reqLen = ~reqLen;
    end
  endtask

  task automatic checkPkt(input int len, input bit scramble);
    int guard = 0;
    logic [63:0] gotBoard, expBoard, gotTs, expTs;
    while (capCnt < 16 + len && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (5) @(negedge clk);
    check("R7", "packet word count", 64'(capCnt), 64'(16 + len));
    check("R1", "start marker", {48'd0, cap[0]}, {48'd0, START_MARK});
    check("R3", "type word", {48'd0, cap[1]}, {48'd0, exHdr[1]});
    check("R3", "size word", {48'd0, cap[2]}, {48'd0, exHdr[2]});
    check("R4", "state word", {48'd0, cap[3]}, {48'd0, exHdr[3]});
    gotBoard = {cap[4], cap[5], cap[6], cap[7]};
    expBoard = {exHdr[4], exHdr[5], exHdr[6], exHdr[7]};
    check(scramble ? "R5" : "R2", "chip id", gotBoard, expBoard);
    check("R2", "firmware word", {48'd0, cap[8]}, {48'd0, exHdr[8]});
    check(scramble ? "R5" : "R2", "trigger count",
          {32'd0, cap[9], cap[10]}, {32'd0, exHdr[9], exHdr[10]});
    gotTs = {cap[11], cap[12], cap[13], cap[14]};
    expTs = {exHdr[11], exHdr[12], exHdr[13], exHdr[14]};
    check("R6", "timestamp", gotTs, expTs);
    for (int i = 0; i < len; i++)
      check("R7", "payload word", {48'd0, cap[15+i]}, {48'd0, pay[i]});
    check("R1", "end marker", {48'd0, cap[(15+len) % 256]}, {48'd0, END_MARK});
    check("R10", "plReady low after packet", {63'd0, plReady}, 64'd0);
  endtask

  task automatic randomInputs();
    stateCode = 8'($urandom % 5);
    clkLocked = 1'($urandom);
    boardId = {32'($urandom), 32'($urandom)};
    fwVersion = 16'($urandom);
    trigCount = 32'($urandom);
  endtask

  bit finished = 1'b0;

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    #2;
    check("R9", "outValid after reset", {63'd0, outValid}, 64'd0);
    check("R9", "reqReady after reset", {63'd0, reqReady}, 64'd1);
    check("R10", "plReady after reset", {63'd0, plReady}, 64'd0);

    // Directed: zero and one word payloads, every type code
    readyMode = 1;
    for (int t = 1; t <= 5; t++) begin
      randomInputs();
      sendPkt(3'(t), (t == 1) ? 0 : t - 1, 1'b0);
      checkPkt((t == 1) ? 0 : t - 1, 1'b0);
    end

    // R5: inputs change right after acceptance
    randomInputs();
    sendPkt(3'd2, 6, 1'b1);
    checkPkt(6, 1'b1);

    // R6: restart with several prescaler settings
    for (int p = 0; p < 3; p++) begin
      usPrescale = 8'(p * 7);
      @(negedge clk);
      runRestart = 1'b1;
      @(negedge clk);
      runRestart = 1'b0;
      repeat (25 + p * 13) @(negedge clk);
      randomInputs();
      sendPkt(3'd3, p, 1'b0);
      checkPkt(p, 1'b0);
    end

    // Random traffic under heavy and light backpressure (R8)
    for (int n = 0; n < 24; n++) begin
      int len;
      readyMode = n % 3;
      usPrescale = 8'($urandom % 16);
      len = $urandom % 41;
      if (n % 5 == 0) len = 0;
      randomInputs();
      sendPkt(3'(1 + $urandom % 5), len, n % 4 == 1);
      checkPkt(len, n % 4 == 1);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule